// File: doc/BRIEF.md
# Embedded Program and Erase Sequencer

This block sequences the internal program and sector-erase operations of a small banked non-volatile array model. Commands come in already decoded, one per cycle, as an operation code with an address and a data word. A program merges new data into a word by bitwise AND, so it can only clear bits. A sector erase restores every word of one sector to all ones. Both operations run for a fixed number of internal cycles, and the busy flag stays high for the whole of that time.

While an operation runs, the block accepts only the commands that make sense in that state, and it drops every other command with no effect. A program can be suspended and later resumed. An erase can be suspended, and while it is suspended a program can be issued to a different sector. When a program finishes, the machine goes back to the context it was started from: plain idle, a lock or secure region mode, or the suspended erase.

A read port returns array words. It returns the status byte instead while status-read mode is active, and also when the address falls in the bank that an operation is using. Reads of any other bank continue normally during the operation.

Top module: `pe_ctrl`

## Requirements
- R1: A program to address A with data D leaves the word at A equal to its old value AND D (0x33 programmed with 0x55 reads back 0x11); no other word changes.
- R2: A sector erase writes 0xFF (all ones) into every word of the sector named by address bits [3:2], whatever word bits [1:0] say, and leaves the other sectors unchanged.
- R3: A program holds the busy flag for exactly 8 cycles, starting with the cycle after the command is accepted. The array word changes at the edge where busy falls.
- R4: A sector erase holds the busy flag for exactly 32 cycles, starting with the cycle after the command is accepted.
- R5: While a program runs, only program-suspend and status-read commands are accepted. Every other command has no effect on the array, the region mode or the operation.
- R6: While an erase runs, only erase-suspend and status-read commands are accepted. Every other command, a program included, is dropped.
- R7: A suspend accepted in a cycle stops the operation's count for that cycle and clears busy. A resume continues from the saved count, so a program suspended after 3 counted cycles stays busy for 5 more cycles after the resume.
- R8: During an operation, a read from the other bank (address bit 3) returns array data. A read from the bank that the operation uses returns the status byte.
- R9: After an accepted status-read command, the read port returns the status byte for every address. The next accepted command of any other kind returns the port to array data.
- R10: A program started from lock mode, secure mode or a suspended erase goes back to that same context when it completes. Lock, secure and exit-region commands are accepted only in idle. Lock and secure are taken only when no region is active, and erase is accepted only from plain idle.
- R11: While an erase is suspended, a program addressed to the suspended sector is rejected. A program to any other sector is accepted.
- R12: While reset is low at a clock edge, any operation is discarded, the status byte becomes 0x00 and every array word becomes 0xFF.
- R13: The status byte reads as the OR of these flags: operation running 0x01, program suspended 0x02, erase suspended 0x04, lock mode 0x08, secure mode 0x10, program active 0x20, erase active 0x40. Bit 7 reads 0.
- R14: Command codes: 0 none, 1 program, 2 sector erase, 3 program suspend, 4 erase suspend, 5 resume, 6 status read, 7 enter lock, 8 enter secure, 9 exit region. Any other code is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command code (R14) |
| cmd_addr | input | AW (4) | Word address {bank, sector, word} |
| cmd_data | input | DW (8) | Program data |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | DW (8) | Array word or status byte |
| status | output | 8 | Status byte (R13) |
| busy | output | 1 | An operation is counting |

## Verification
A wrong state or count shows up on the status byte in the first cycle after the edge where it happens, because every flag in that byte comes straight from the sequencer registers. A wrong filter decision, or a wrong return context, therefore shows up at the next edge. A wrong array update stays hidden until that word is read. For this reason the bench compares the read port and the status against a behavioural model on every cycle, and it also reads back each touched word as soon as the operation ends. Counting faults appear as a busy window that is too short or too long, which the bench measures cycle by cycle.

// File: rtl/pe_pkg.sv
// Shared types for the program/erase sequencer.
// Assumes: command codes are 4 bits wide; status is a single byte.
package pe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PSUSP,
        ST_ERASE,
        ST_ESUSP
    } pe_state_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_LOCK,
        RG_SECURE
    } pe_region_t;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_PROG,
        ACT_ERASE,
        ACT_PSUSP,
        ACT_ESUSP,
        ACT_PRES,
        ACT_ERES,
        ACT_LOCK,
        ACT_SECURE,
        ACT_EXIT,
        ACT_STATUS
    } pe_act_t;

    localparam logic [3:0] OP_NOP    = 4'd0;
    localparam logic [3:0] OP_PROG   = 4'd1;
    localparam logic [3:0] OP_ERASE  = 4'd2;
    localparam logic [3:0] OP_PSUSP  = 4'd3;
    localparam logic [3:0] OP_ESUSP  = 4'd4;
    localparam logic [3:0] OP_RESUME = 4'd5;
    localparam logic [3:0] OP_STATUS = 4'd6;
    localparam logic [3:0] OP_LOCK   = 4'd7;
    localparam logic [3:0] OP_SECURE = 4'd8;
    localparam logic [3:0] OP_EXIT   = 4'd9;

    localparam int SB_BUSY   = 0;
    localparam int SB_PSUSP  = 1;
    localparam int SB_ESUSP  = 2;
    localparam int SB_LOCK   = 3;
    localparam int SB_SECURE = 4;
    localparam int SB_PACT   = 5;
    localparam int SB_EACT   = 6;

endpackage

// File: rtl/pe_cmd_filter.sv
// Command filter: turns a raw command into the single action the current
// state permits, or ACT_NONE when the command is to be dropped.
// Assumes: purely combinational; state inputs are registered elsewhere.
module pe_cmd_filter
    import pe_pkg::*;
#(
    parameter int SECT_W = 2
) (
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [SECT_W-1:0] cmd_sect,
    input  pe_state_t         state,
    input  pe_region_t        region,
    input  logic [SECT_W-1:0] e_sect,
    output pe_act_t           act
);

    // Per-state whitelist of accepted commands.
    always_comb begin
        act = ACT_NONE;
        if (cmd_valid) begin
            if (cmd_op == OP_STATUS) begin
                act = ACT_STATUS;
            end else begin
                case (state)
                    ST_IDLE: begin
                        case (cmd_op)
                            OP_PROG:   act = ACT_PROG;
                            OP_ERASE:  if (region == RG_NONE) act = ACT_ERASE;
                            OP_LOCK:   if (region == RG_NONE) act = ACT_LOCK;
                            OP_SECURE: if (region == RG_NONE) act = ACT_SECURE;
                            OP_EXIT:   if (region != RG_NONE) act = ACT_EXIT;
                            default:   act = ACT_NONE;
                        endcase
                    end
                    ST_PROG:  if (cmd_op == OP_PSUSP)  act = ACT_PSUSP;
                    ST_PSUSP: if (cmd_op == OP_RESUME) act = ACT_PRES;
                    ST_ERASE: if (cmd_op == OP_ESUSP)  act = ACT_ESUSP;
                    ST_ESUSP: begin
                        if (cmd_op == OP_PROG && cmd_sect != e_sect) act = ACT_PROG;
                        else if (cmd_op == OP_RESUME)                  act = ACT_ERES;
                    end
                    default: act = ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pe_seq.sv
// Operation sequencer: holds the state, the region mode, the program and
// erase contexts with their own counters, and the status-read flag.
// Emits one-cycle write strobes to the array on completion.
// Assumes: PROG_CYC and ERASE_CYC are at least 2; act comes from the filter.
module pe_seq
    import pe_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 32,
    localparam int PCW      = $clog2(PROG_CYC),
    localparam int ECW      = $clog2(ERASE_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pe_act_t           act,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DW-1:0]     cmd_data,
    output pe_state_t         state,
    output pe_region_t        region,
    output logic              ret_esusp,
    output logic [AW-1:0]     p_addr,
    output logic [DW-1:0]     p_data,
    output logic [SECT_W-1:0] e_sect,
    output logic              smode,
    output logic              prog_we,
    output logic              erase_we
);

    logic [PCW-1:0] pcnt;
    logic [ECW-1:0] ecnt;
    logic           prog_last;
    logic           erase_last;

    // Completion of the current count, unless a suspend wins this cycle.
    always_comb begin
        prog_last  = (state == ST_PROG)  && (act != ACT_PSUSP) && (pcnt == PCW'(PROG_CYC - 1));
        erase_last = (state == ST_ERASE) && (act != ACT_ESUSP) && (ecnt == ECW'(ERASE_CYC - 1));
        prog_we    = prog_last;
        erase_we   = erase_last;
    end

    // Status-read mode: set by status read, cleared by any other accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)                  smode <= 1'b0;
        else if (act == ACT_STATUS)  smode <= 1'b1;
        else if (act != ACT_NONE)    smode <= 1'b0;
    end

    // Region mode register, only changed from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region <= RG_NONE;
        end else if (state == ST_IDLE) begin
            case (act)
                ACT_LOCK:   region <= RG_LOCK;
                ACT_SECURE: region <= RG_SECURE;
                ACT_EXIT:   region <= RG_NONE;
                default:    region <= region;
            endcase
        end
    end

    // Main state machine with the program context and its counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_esusp <= 1'b0;
            p_addr    <= '0;
            p_data    <= '0;
            pcnt      <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_ESUSP: begin
                    if (act == ACT_PROG) begin
                        state     <= ST_PROG;
                        p_addr    <= cmd_addr;
                        p_data    <= cmd_data;
                        pcnt      <= '0;
                        ret_esusp <= (state == ST_ESUSP);
                    end else if (act == ACT_ERASE) begin
                        state <= ST_ERASE;
                    end else if (act == ACT_ERES) begin
                        state <= ST_ERASE;
                    end
                end
                ST_PROG: begin
                    if (act == ACT_PSUSP)  state <= ST_PSUSP;
                    else if (prog_last)    state <= ret_esusp ? ST_ESUSP : ST_IDLE;
                    else                   pcnt  <= pcnt + PCW'(1);
                end
                ST_PSUSP: begin
                    if (act == ACT_PRES) state <= ST_PROG;
                end
                ST_ERASE: begin
                    if (act == ACT_ESUSP)  state <= ST_ESUSP;
                    else if (erase_last)   state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Erase context: target sector and its own counter, frozen while suspended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_sect <= '0;
            ecnt   <= '0;
        end else if (state == ST_IDLE && act == ACT_ERASE) begin
            e_sect <= cmd_addr[AW-1 -: SECT_W];
            ecnt   <= '0;
        end else if (state == ST_ERASE && act != ACT_ESUSP && !erase_last) begin
            ecnt <= ecnt + ECW'(1);
        end
    end

endmodule

// File: rtl/pe_array.sv
// Array model: one register per word. A program ANDs new data into the
// addressed word; an erase sets every word of one sector to all ones.
// Reset fills the array with ones. Read is combinational.
// Assumes: address is {sector, word}; prog_we and erase_we never coincide.
module pe_array #(
    parameter int NWORDS = 16,
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int WORD_W = 2,
    localparam int SECT_W = AW - WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [AW-1:0]     prog_addr,
    input  logic [DW-1:0]     prog_data,
    input  logic              erase_we,
    input  logic [SECT_W-1:0] erase_sect,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_word
);

    logic [NWORDS-1:0][DW-1:0] words;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [AW-1:0] GA = AW'(g);
        logic [DW-1:0] word_q;

        // Per-word update: AND on program, ones on sector erase.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '1;
            else if (prog_we && prog_addr == GA)
                word_q <= word_q & prog_data;
            else if (erase_we && erase_sect == GA[AW-1:WORD_W])
                word_q <= '1;
        end

        assign words[g] = word_q;
    end

    // Combinational read mux.
    always_comb rd_word = words[rd_addr];

endmodule

// File: rtl/pe_ctrl.sv
// Top level of the program/erase sequencer. Wires filter, sequencer and
// array together, builds the status byte and steers the read port.
// Assumes: BANKS, SECTS_PER_BANK and WORDS_PER_SECT are powers of two >= 2; DW >= 8.
module pe_ctrl
    import pe_pkg::*;
#(
    parameter int BANKS          = 2,
    parameter int SECTS_PER_BANK = 2,
    parameter int WORDS_PER_SECT = 4,
    parameter int DW             = 8,
    parameter int PROG_CYC       = 8,
    parameter int ERASE_CYC      = 32,
    localparam int NWORDS = BANKS * SECTS_PER_BANK * WORDS_PER_SECT,
    localparam int AW     = $clog2(NWORDS),
    localparam int WORD_W = $clog2(WORDS_PER_SECT),
    localparam int SECT_W = AW - WORD_W,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [7:0]    status,
    output logic          busy
);

    pe_act_t           act;
    pe_state_t         state;
    pe_region_t        region;
    logic              ret_esusp;
    logic [AW-1:0]     p_addr;
    logic [DW-1:0]     p_data;
    logic [SECT_W-1:0] e_sect;
    logic              smode;
    logic              prog_we;
    logic              erase_we;
    logic [DW-1:0]     arr_word;
    logic              bank_hit;

    pe_cmd_filter #(.SECT_W(SECT_W)) u_filter (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_sect  (cmd_addr[AW-1 -: SECT_W]),
        .state     (state),
        .region    (region),
        .e_sect    (e_sect),
        .act       (act)
    );

    pe_seq #(
        .AW        (AW),
        .DW        (DW),
        .SECT_W    (SECT_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .state     (state),
        .region    (region),
        .ret_esusp (ret_esusp),
        .p_addr    (p_addr),
        .p_data    (p_data),
        .e_sect    (e_sect),
        .smode     (smode),
        .prog_we   (prog_we),
        .erase_we  (erase_we)
    );

    pe_array #(
        .NWORDS (NWORDS),
        .AW     (AW),
        .DW     (DW),
        .WORD_W (WORD_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_addr  (p_addr),
        .prog_data  (p_data),
        .erase_we   (erase_we),
        .erase_sect (e_sect),
        .rd_addr    (rd_addr),
        .rd_word    (arr_word)
    );

    // Status byte assembled from sequencer state.
    always_comb begin
        status            = '0;
        status[SB_PACT]   = (state == ST_PROG);
        status[SB_EACT]   = (state == ST_ERASE);
        status[SB_BUSY]   = status[SB_PACT] | status[SB_EACT];
        status[SB_PSUSP]  = (state == ST_PSUSP);
        status[SB_ESUSP]  = (state == ST_ESUSP) ||
                            (ret_esusp && (state == ST_PROG || state == ST_PSUSP));
        status[SB_LOCK]   = (region == RG_LOCK);
        status[SB_SECURE] = (region == RG_SECURE);
        busy              = status[SB_BUSY];
    end

    // Read steering: status in status mode or when the busy bank is addressed.
    always_comb begin
        bank_hit = ((state == ST_PROG)  && (rd_addr[AW-1 -: BANK_W] == p_addr[AW-1 -: BANK_W])) ||
                   ((state == ST_ERASE) && (rd_addr[AW-1 -: BANK_W] == e_sect[SECT_W-1 -: BANK_W]));
        rd_data  = (smode || bank_hit) ? DW'(status) : arr_word;
    end

endmodule

// File: rtl/pe_ctrl_chk.sv
// Assertion checker for pe_ctrl, attached with bind below.
// Assumes: status bit layout of the package; counts windows with counters.
module pe_ctrl_chk
    import pe_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic [6:0] status,
    input logic       busy
);

    int unsigned prun;
    int unsigned erun;

    // Length of the current uninterrupted program / erase activity stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prun <= 0;
            erun <= 0;
        end else begin
            prun <= status[SB_PACT] ? prun + 1 : 0;
            erun <= status[SB_EACT] ? erun + 1 : 0;
        end
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 7'd0 && !busy));

    // R3
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_PACT] |-> (prun < PROG_CYC));

    // R4
    erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_EACT] |-> (erun < ERASE_CYC));

    // R5
    prog_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_PACT] && cmd_valid && cmd_op == OP_ERASE) |=> !status[SB_EACT]);

    // R6
    erase_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_EACT] && cmd_valid && cmd_op == OP_PROG) |=> !status[SB_PACT]);

    // R7
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[SB_PSUSP] && !(cmd_valid && cmd_op == OP_RESUME)) |=> status[SB_PSUSP]);

    // R7
    susp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_PSUSP] |-> !busy);

    // R13
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status[SB_PACT], status[SB_EACT], status[SB_PSUSP]}) &&
        (busy == (status[SB_PACT] | status[SB_EACT])));

endmodule

bind pe_ctrl pe_ctrl_chk #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_pe_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .status    (status[6:0]),
    .busy      (busy)
);

// File: tb/test_pe_ctrl.sv
`timescale 1ns/1ps
module test_pe_ctrl;

    localparam int C_PROG = 1, C_ERASE = 2, C_PSUSP = 3, C_ESUSP = 4, C_RESUME = 5;
    localparam int C_STATUS = 6, C_LOCK = 7, C_SECURE = 8, C_EXIT = 9;
    localparam int T_PROG = 8, T_ERASE = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic       busy;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R12";

    // Behavioural reference model state
    int ms = 0;      // 0 idle, 1 program, 2 program suspended, 3 erase, 4 erase suspended
    int mreg = 0;    // 0 none, 1 lock, 2 secure
    int mpc = 0, mec = 0, mpa = 0, mpd = 0, mes = 0, mret = 0, msm = 0;
    int mem [16];

    always #2.5 clk = ~clk;

    pe_ctrl i_pe_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status    (status),
        .busy      (busy)
    );

    function automatic int m_status();
        int s = 0;
        if (ms == 1 || ms == 3) s |= 1;
        if (ms == 2) s |= 2;
        if (ms == 4 || (mret == 1 && (ms == 1 || ms == 2))) s |= 4;
        if (mreg == 1) s |= 8;
        if (mreg == 2) s |= 16;
        if (ms == 1) s |= 32;
        if (ms == 3) s |= 64;
        return s;
    endfunction

    function automatic int m_read(int a);
        if (msm == 1) return m_status();
        if (ms == 1 && (a / 8) == (mpa / 8)) return m_status();
        if (ms == 3 && (a / 8) == (mes / 2)) return m_status();
        return mem[a];
    endfunction

    // Model advance on each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        int op, a, d;
        bit acc;
        started = 1;
        cyc++;
        if (!rst_n) begin
            ms = 0; mreg = 0; mpc = 0; mec = 0; mpa = 0; mpd = 0; mes = 0; mret = 0; msm = 0;
            for (int i = 0; i < 16; i++) mem[i] = 255;
        end else begin
            op = cmd_valid ? int'(cmd_op) : 0;
            a = int'(cmd_addr);
            d = int'(cmd_data);
            acc = 0;
            case (ms)
                0: begin
                    if (op == C_PROG) begin ms = 1; mpa = a; mpd = d; mpc = 0; mret = 0; acc = 1; end
                    else if (op == C_ERASE && mreg == 0) begin ms = 3; mes = a / 4; mec = 0; acc = 1; end
                    else if (op == C_LOCK && mreg == 0) begin mreg = 1; acc = 1; end
                    else if (op == C_SECURE && mreg == 0) begin mreg = 2; acc = 1; end
                    else if (op == C_EXIT && mreg != 0) begin mreg = 0; acc = 1; end
                end
                1: begin
                    if (op == C_PSUSP) begin ms = 2; acc = 1; end
                    else if (mpc == T_PROG - 1) begin mem[mpa] = mem[mpa] & mpd; ms = (mret == 1) ? 4 : 0; end
                    else mpc++;
                end
                2: if (op == C_RESUME) begin ms = 1; acc = 1; end
                3: begin
                    if (op == C_ESUSP) begin ms = 4; acc = 1; end
                    else if (mec == T_ERASE - 1) begin
                        for (int i = 0; i < 4; i++) mem[mes * 4 + i] = 255;
                        ms = 0;
                    end else mec++;
                end
                4: begin
                    if (op == C_PROG && (a / 4) != mes) begin ms = 1; mpa = a; mpd = d; mpc = 0; mret = 1; acc = 1; end
                    else if (op == C_RESUME) begin ms = 3; acc = 1; end
                end
                default: ms = 0;
            endcase
            if (op == C_STATUS) msm = 1;
            else if (acc) msm = 0;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        nchk++;
        if (actual !== expected) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, actual, expected, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the model, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (started && !done) begin
            chk({cur_req, " status"}, int'(status), m_status());
            chk({cur_req, " rd_data"}, int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic cmd(input int op, input int a, input int d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_addr  = 4'(a);
        cmd_data  = 8'(d);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 4'(a);
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 200) begin
            n++;
            @(posedge clk);
            #1;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        cur_req = "R12";
        chk("R12 reset status", int'(status), 0);
        rd(5, v); chk("R12 reset array", v, 8'hFF);

        cur_req = "R14";
        cmd(15, 5, 0);
        chk("R14 unknown code ignored", int'(status), 0);
        rd(5, v); chk("R14 unknown code array", v, 8'hFF);

        cur_req = "R3";
        cmd(C_PROG, 1, 8'h33);
        count_busy(n); chk("R3 program busy cycles", n, T_PROG);
        cur_req = "R1";
        cmd(C_PROG, 1, 8'h55);
        count_busy(n);
        rd(1, v); chk("R1 AND merge", v, 8'h11);
        cmd(C_PROG, 4, 8'h0F);
        count_busy(n);

        cur_req = "R4";
        cmd(C_ERASE, 2, 0);
        count_busy(n); chk("R4 erase busy cycles", n, T_ERASE);
        cur_req = "R2";
        rd(1, v); chk("R2 sector erased", v, 8'hFF);
        rd(4, v); chk("R2 other sector kept", v, 8'h0F);

        cur_req = "R5";
        cmd(C_PROG, 2, 8'h3C);
        cmd(C_ERASE, 0, 0);
        cmd(C_LOCK, 0, 0);
        cmd(C_RESUME, 0, 0);
        chk("R5 status during program", int'(status), 8'h21);
        count_busy(n);
        rd(2, v); chk("R5 erase ignored", v, 8'h3C);
        chk("R5 lock ignored", int'(status), 0);

        cur_req = "R8";
        cmd(C_PROG, 3, 8'hF0);
        rd(8, v); chk("R8 other bank read", v, 8'hFF);
        rd(3, v); chk("R8 busy bank read", v, 8'h21);
        count_busy(n);
        rd(3, v); chk("R8 word after program", v, 8'hF0);

        cur_req = "R7";
        cmd(C_PROG, 9, 8'hA5);
        repeat (3) begin @(posedge clk); #1; end
        cmd(C_PSUSP, 0, 0);
        chk("R7 suspended status", int'(status), 8'h02);
        repeat (10) begin @(posedge clk); #1; end
        chk("R7 suspended holds", int'(status), 8'h02);
        rd(9, v); chk("R7 word untouched while suspended", v, 8'hFF);
        cmd(C_RESUME, 0, 0);
        count_busy(n); chk("R7 remaining busy cycles", n, T_PROG - 3);
        rd(9, v); chk("R7 word after resume", v, 8'hA5);

        cur_req = "R9";
        cmd(C_STATUS, 0, 0);
        rd(9, v); chk("R9 status mode read", v, 0);
        cmd(C_LOCK, 0, 0);
        rd(9, v); chk("R9 array mode restored", v, 8'hA5);

        cur_req = "R10";
        chk("R13 lock flag", int'(status), 8'h08);
        cmd(C_PROG, 10, 8'h77);
        chk("R13 program in lock", int'(status), 8'h29);
        count_busy(n);
        chk("R10 back to lock", int'(status), 8'h08);
        cmd(C_SECURE, 0, 0);
        chk("R10 secure ignored in lock", int'(status), 8'h08);
        cmd(C_ERASE, 0, 0);
        chk("R10 erase ignored in lock", int'(status), 8'h08);
        cmd(C_EXIT, 0, 0);
        chk("R10 exit region", int'(status), 0);
        cmd(C_SECURE, 0, 0);
        cmd(C_PROG, 11, 8'h3F);
        count_busy(n);
        chk("R10 back to secure", int'(status), 8'h10);
        cmd(C_EXIT, 0, 0);

        cur_req = "R6";
        cmd(C_ERASE, 8, 0);
        chk("R6 erase status", int'(status), 8'h41);
        cmd(C_PROG, 0, 0);
        chk("R6 program ignored", int'(status), 8'h41);
        cmd(C_ESUSP, 0, 0);
        chk("R6 erase suspended", int'(status), 8'h04);
        cur_req = "R11";
        cmd(C_PROG, 9, 0);
        chk("R11 same-sector program rejected", int'(status), 8'h04);
        cmd(C_PROG, 4, 8'h0A);
        chk("R11 other-sector program", int'(status), 8'h25);
        count_busy(n); chk("R3 program under erase suspend", n, T_PROG);
        chk("R10 back to erase suspend", int'(status), 8'h04);
        rd(4, v); chk("R1 program under suspend", v, 8'h0A);
        rd(0, v); chk("R6 dropped program left word", v, 8'hFF);
        cmd(C_RESUME, 0, 0);
        chk("R7 erase resumed", int'(status), 8'h41);
        count_busy(n);
        rd(9, v); chk("R2 erased word 9", v, 8'hFF);
        rd(10, v); chk("R2 erased word 10", v, 8'hFF);

        cur_req = "R12";
        cmd(C_PROG, 12, 0);
        repeat (2) begin @(posedge clk); #1; end
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R12 abort status", int'(status), 0);
        rd(12, v); chk("R12 aborted word", v, 8'hFF);

        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule